// File: doc/BRIEF.md
# Parallel Flash Burst Read Controller

This block is a 32-bit memory-mapped data slave in front of a word-addressed flash storage model. It accepts one command at a time: a single read, an incrementing burst read of up to `MAX_BURST` words, a wrapping burst read of a fixed length, or a single-word program. For reads it produces the beat address sequence itself and returns one word per cycle, marking each with `avs_readdatavalid`. While a command is being served, `avs_waitrequest` holds off the master.

The storage is split into equal sectors, and each sector can be locked by a level on `sector_lock`. A read of a word past the end of the array, or inside a locked sector, returns all ones and clears the read success flag. A program stores the AND of the old word and the new data, which is how flash bits behave: a program can only move bits from 1 to 0. It succeeds only with a burst count of one, an address inside the array and an unlocked sector. A three-state busy code reports whether the block is idle, reading or programming.

Top module: `flash_burst_ctrl`

## Requirements
- R1: After reset `avs_waitrequest`, `avs_readdatavalid`, `read_ok` and `write_ok` are 0, `busy_code` is 2'b00, and every word of the array reads as 32'hFFFFFFFF.
- R2: A read with `burst_wrap`=0 and a burst count N in 1..MAX_BURST returns N words from consecutive addresses. The first word comes in the cycle after the command is accepted, and the other words follow with one word in every cycle.
- R3: An incrementing burst that moves past the last word (NUM_WORDS-1) continues at word 0.
- R4: A read with `burst_wrap`=1 and a count equal to WRAP_LEN (2 or 4) starts at any word and stays within the aligned WRAP_LEN-word block. With WRAP_LEN=4, a start at word 2 gives 2,3,0,1. With WRAP_LEN=2, a start at word 1 gives 1,0. A block at the top of the array also stays inside the array.
- R5: An illegal count returns 32'hFFFFFFFF for every requested beat and leaves `read_ok` at 0. For a wrapping read, an illegal count is any count other than WRAP_LEN. For an incrementing read, it is 0 or more than MAX_BURST. A count of 0 is served as a single beat.
- R6: A beat whose address is NUM_WORDS or above, or lies in a sector whose `sector_lock` bit is 1 (sector = address / SECT_WORDS), returns 32'hFFFFFFFF and leaves `read_ok` at 0 after the burst. A burst with no such beat leaves `read_ok` at 1.
- R7: A program with a count of 1, an address inside the array and an unlocked sector changes the word to (old AND data) and sets `write_ok` to 1.
- R8: A program with a count other than 1, an address outside the array or a locked sector leaves the array unchanged and sets `write_ok` to 0.
- R9: `busy_code` is 2'b11 while a read is being served, 2'b10 while a program is being served, and 2'b00 when idle.
- R10: `avs_waitrequest` is 1 from the cycle after acceptance until the last beat of a burst has been issued. No further command is taken during that time, and the burst returns exactly its beat count.
- R11: When `avs_read` and `avs_write` are both 1, the read is served and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| avs_address | input | ADDR_W | Word address of the command |
| avs_read | input | 1 | Read request |
| avs_write | input | 1 | Program request |
| avs_writedata | input | 32 | Program data |
| avs_burstcount | input | BC_W | Requested number of words |
| burst_wrap | input | 1 | 1 selects a wrapping burst for the read |
| sector_lock | input | NUM_SECT | One lock bit per sector |
| avs_waitrequest | output | 1 | Command not accepted this cycle |
| avs_readdata | output | 32 | Returned word |
| avs_readdatavalid | output | 1 | Marks a returned word |
| busy_code | output | 2 | 00 idle, 11 reading, 10 programming |
| read_ok | output | 1 | Last read burst fully legal |
| write_ok | output | 1 | Last program succeeded |

## Verification
The bench targets the seams of the address sequence. It runs incrementing bursts that cross the top of the array, and wrapping bursts from unaligned starts, including the topmost block and a second instance built for length 2. A design with the wrap mask off by one would leave the block or repeat a word, and one without rollover would read past the array as all ones. Bursts with counts of 0, 3 and 200, and bursts that run into a locked sector, check that the design returns exactly the requested number of all-ones beats and clears the flag. A design that dropped beats or stopped early would stall the master. Failed programs (wrong count, out of range, locked) are followed by read-back, so a design that wrote anyway or skipped the AND with the old word shows a wrong value at the data port.

// File: rtl/flash_burst_pkg.sv
package flash_burst_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_PROG = 2'b10,
    ST_READ = 2'b11
  } ctrl_state_e;

  // next word of an incrementing burst: rolls to 0 after the last array word,
  // otherwise counts up modulo the address space
  function automatic int unsigned seq_incr(input int unsigned a,
                                           input int unsigned words,
                                           input int unsigned span);
    return (a == words - 1) ? 0 : (a + 1) % span;
  endfunction

  // next word of a wrapping burst: low bits count, upper bits stay
  function automatic int unsigned seq_wrap(input int unsigned a,
                                           input int unsigned len);
    return (a & ~(len - 1)) | ((a + 1) & (len - 1));
  endfunction

endpackage

// File: rtl/flash_addr_seq.sv
module flash_addr_seq
  import flash_burst_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_WORDS = 192,
  parameter int unsigned WRAP_LEN  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              wrap_in,
  input  logic              step,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam int unsigned SPAN = 1 << ADDR_W;

  logic [ADDR_W-1:0] cur_q;
  logic              wrap_q;
  logic [ADDR_W-1:0] next_addr;

  always_comb begin
    if (wrap_q) next_addr = ADDR_W'(seq_wrap(32'(cur_q), WRAP_LEN));
    else        next_addr = ADDR_W'(seq_incr(32'(cur_q), NUM_WORDS, SPAN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      wrap_q <= 1'b0;
    end else if (load) begin
      cur_q  <= start_addr;
      wrap_q <= wrap_in;
    end else if (step) begin
      cur_q  <= next_addr;
    end
  end

  assign cur_addr = cur_q;

  AST_WRAP_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && wrap_q) |=> (32'(cur_addr) / WRAP_LEN) == $past(32'(cur_addr) / WRAP_LEN)); // R4
  AST_INCR_ROLLOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !wrap_q && 32'(cur_addr) == NUM_WORDS - 1) |=> cur_addr == '0); // R3

endmodule

// File: rtl/flash_word_store.sv
module flash_word_store #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_WORDS  = 192,
  parameter int unsigned SECT_WORDS = 64,
  parameter int unsigned NUM_SECT   = NUM_WORDS / SECT_WORDS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SECT-1:0] lock,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  output logic                rd_good,
  input  logic                pg_en,
  input  logic [ADDR_W-1:0]   pg_addr,
  input  logic [DATA_W-1:0]   pg_data,
  output logic                pg_good
);
  logic [DATA_W-1:0] mem [NUM_WORDS];

  function automatic logic word_in_range(input logic [ADDR_W-1:0] a);
    return 32'(a) < NUM_WORDS;
  endfunction

  function automatic logic word_locked(input logic [ADDR_W-1:0] a,
                                       input logic [NUM_SECT-1:0] m);
    logic hit;
    hit = 1'b0;
    for (int s = 0; s < int'(NUM_SECT); s++)
      if (32'(a) / SECT_WORDS == 32'(s)) hit = m[s];
    return hit;
  endfunction

  assign rd_good = word_in_range(rd_addr) && !word_locked(rd_addr, lock);
  assign rd_data = rd_good ? mem[rd_addr] : '1;
  assign pg_good = word_in_range(pg_addr) && !word_locked(pg_addr, lock);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(NUM_WORDS); i++) mem[i] <= '1;
    end else if (pg_en && pg_good) begin
      mem[pg_addr] <= mem[pg_addr] & pg_data;
    end
  end

  AST_BLOCKED_PROG_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_en && !pg_good && word_in_range(pg_addr)) |=> mem[$past(pg_addr)] == $past(mem[pg_addr])); // R8
  AST_PROG_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_en && pg_good) |=> (mem[$past(pg_addr)] & ~$past(mem[pg_addr])) == '0); // R7

endmodule

// File: rtl/flash_burst_ctrl.sv
module flash_burst_ctrl
  import flash_burst_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned NUM_WORDS  = 192,
  parameter int unsigned SECT_WORDS = 64,
  parameter int unsigned WRAP_LEN   = 4,
  parameter int unsigned MAX_BURST  = 128,
  parameter int unsigned BC_W       = 8,
  parameter int unsigned NUM_SECT   = NUM_WORDS / SECT_WORDS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   avs_address,
  input  logic                avs_read,
  input  logic                avs_write,
  input  logic [31:0]         avs_writedata,
  input  logic [BC_W-1:0]     avs_burstcount,
  input  logic                burst_wrap,
  input  logic [NUM_SECT-1:0] sector_lock,
  output logic                avs_waitrequest,
  output logic [31:0]         avs_readdata,
  output logic                avs_readdatavalid,
  output logic [1:0]          busy_code,
  output logic                read_ok,
  output logic                write_ok
);
  localparam int unsigned DATA_W = 32;

  ctrl_state_e       state_q;
  logic [BC_W-1:0]   beats_q;
  logic              bad_q;
  logic              wlen_ok_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              rd_ok_q, wr_ok_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  // named events
  logic cmd_rd, cmd_wr, count_bad, beat_step, last_beat, beat_fail, pg_fire;
  logic [ADDR_W-1:0] beat_addr;
  logic [DATA_W-1:0] store_data;
  logic              store_good, pg_good;

  assign cmd_rd    = avs_read && (state_q == ST_IDLE);
  assign cmd_wr    = avs_write && !avs_read && (state_q == ST_IDLE);
  assign count_bad = burst_wrap ? (avs_burstcount != BC_W'(WRAP_LEN))
                                : (avs_burstcount == '0 || 32'(avs_burstcount) > MAX_BURST);
  assign beat_step = (state_q == ST_READ);
  assign last_beat = beat_step && (beats_q == BC_W'(1));
  assign beat_fail = beat_step && (bad_q || !store_good);
  assign pg_fire   = (state_q == ST_PROG) && wlen_ok_q;

  flash_addr_seq #(
    .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .WRAP_LEN(WRAP_LEN)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .load(cmd_rd), .start_addr(avs_address),
    .wrap_in(burst_wrap), .step(beat_step), .cur_addr(beat_addr)
  );

  flash_word_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS),
    .SECT_WORDS(SECT_WORDS), .NUM_SECT(NUM_SECT)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .lock(sector_lock),
    .rd_addr(beat_addr), .rd_data(store_data), .rd_good(store_good),
    .pg_en(pg_fire), .pg_addr(waddr_q), .pg_data(wdata_q), .pg_good(pg_good)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      beats_q   <= '0;
      bad_q     <= 1'b0;
      wlen_ok_q <= 1'b0;
      waddr_q   <= '0;
      wdata_q   <= '0;
      rd_ok_q   <= 1'b0;
      wr_ok_q   <= 1'b0;
      rdata_q   <= '0;
      rvalid_q  <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_rd) begin
            beats_q <= (avs_burstcount == '0) ? BC_W'(1) : avs_burstcount;
            bad_q   <= count_bad;
            rd_ok_q <= !count_bad;
            state_q <= ST_READ;
          end else if (cmd_wr) begin
            waddr_q   <= avs_address;
            wdata_q   <= avs_writedata;
            wlen_ok_q <= (avs_burstcount == BC_W'(1));
            state_q   <= ST_PROG;
          end
        end
        ST_READ: begin
          rdata_q  <= bad_q ? '1 : store_data;
          rvalid_q <= 1'b1;
          if (beat_fail) rd_ok_q <= 1'b0;
          beats_q  <= beats_q - BC_W'(1);
          if (last_beat) state_q <= ST_IDLE;
        end
        ST_PROG: begin
          wr_ok_q <= wlen_ok_q && pg_good;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign avs_waitrequest   = (state_q != ST_IDLE);
  assign avs_readdata      = rdata_q;
  assign avs_readdatavalid = rvalid_q;
  assign busy_code         = state_q;
  assign read_ok           = rd_ok_q;
  assign write_ok          = wr_ok_q;

  AST_BEAT_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    beat_step |=> avs_readdatavalid); // R2
  AST_VALID_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    avs_readdatavalid |-> $past(beat_step)); // R2
  AST_BAD_COUNT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_step && bad_q) |=> (avs_readdata == '1 && !read_ok)); // R5
  AST_SHORT_PROG_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_PROG) && !wlen_ok_q) |=> !write_ok); // R8
  AST_HOLD_OFF_MID_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_step && !last_beat) |=> (avs_waitrequest && busy_code == 2'b11)); // R10

endmodule

// File: tb/tb_flash_burst_ctrl.sv
module tb_flash_burst_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8, NW = 192, SW = 64, NS = 3, BCW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic rd = 1'b0, wr = 1'b0, wrap = 1'b0;
  logic [31:0] wdata = '0;
  logic [BCW-1:0] bcnt = '0;
  logic [NS-1:0] lock = '0;

  logic wait_a, rv_a, rok_a, wok_a, wait_b, rv_b, rok_b, wok_b;
  logic [31:0] rdat_a, rdat_b;
  logic [1:0] busy_a, busy_b;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] model [NW];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_burst_ctrl #(.WRAP_LEN(4)) dut (
    .clk(clk), .rst_n(rst_n), .avs_address(addr), .avs_read(rd), .avs_write(wr),
    .avs_writedata(wdata), .avs_burstcount(bcnt), .burst_wrap(wrap), .sector_lock(lock),
    .avs_waitrequest(wait_a), .avs_readdata(rdat_a), .avs_readdatavalid(rv_a),
    .busy_code(busy_a), .read_ok(rok_a), .write_ok(wok_a));

  flash_burst_ctrl #(.WRAP_LEN(2)) dut_w2 (
    .clk(clk), .rst_n(rst_n), .avs_address(addr), .avs_read(rd), .avs_write(wr),
    .avs_writedata(wdata), .avs_burstcount(bcnt), .burst_wrap(wrap), .sector_lock(lock),
    .avs_waitrequest(wait_b), .avs_readdata(rdat_b), .avs_readdatavalid(rv_b),
    .busy_code(busy_b), .read_ok(rok_b), .write_ok(wok_b));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_addr(input int a, input int i, input bit w, input int len);
    int x;
    if (w) return (a / len) * len + ((a % len) + i) % len;
    x = a;
    for (int k = 0; k < i; k++) x = (x == NW - 1) ? 0 : (x + 1) % 256;
    return x;
  endfunction

  function automatic logic [31:0] exp_word(input int a);
    if (a >= NW) return 32'hFFFF_FFFF;
    if (lock[a / SW]) return 32'hFFFF_FFFF;
    return model[a];
  endfunction

  task automatic wait_idle();
    @(negedge clk);
    while (wait_a) @(negedge clk);
  endtask

  // one read command; checks busy, hold-off, beat timing, data and read_ok
  task automatic run_read(input string req, input int a, input int cnt, input bit w, input bit useb);
    int len, nexp, bad_beats, bad_timing, first_bad_i;
    bit cnt_bad, all_good;
    logic [31:0] first_act, first_exp;
    len = useb ? 2 : 4;
    cnt_bad = w ? (cnt != len) : (cnt == 0 || cnt > 128);
    nexp = (cnt == 0) ? 1 : cnt;
    wait_idle();
    addr = AW'(a); bcnt = BCW'(cnt); wrap = w; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    check((useb ? busy_b : busy_a) == 2'b11, {req, " R9 busy reading"}, 32'(busy_a), 32'h3);
    check((useb ? wait_b : wait_a) == 1'b1, {req, " R10 waitrequest"}, 32'(wait_a), 32'h1);
    bad_beats = 0; bad_timing = 0; all_good = !cnt_bad;
    first_act = '0; first_exp = '0; first_bad_i = -1;
    for (int k = 0; k < nexp + 2; k++) begin
      logic v; logic [31:0] d, e; int ea;
      @(negedge clk);
      v = useb ? rv_b : rv_a;
      d = useb ? rdat_b : rdat_a;
      if (v != (k < nexp)) bad_timing++;
      if (k < nexp) begin
        ea = exp_addr(a, k, w, len);
        e = cnt_bad ? 32'hFFFF_FFFF : exp_word(ea);
        if (!cnt_bad && (ea >= NW || lock[ea / SW])) all_good = 0;
        if (d !== e) begin
          if (first_bad_i < 0) begin first_bad_i = k; first_act = d; first_exp = e; end
          bad_beats++;
        end
      end
      if (k == nexp - 1)
        check((useb ? wait_b : wait_a) == 1'b0, {req, " R10 release after last beat"}, 32'(wait_a), 32'h0);
    end
    check(bad_timing == 0, {req, " R10 beat count/spacing"}, 32'(bad_timing), 32'h0);
    check(bad_beats == 0, {req, " beat data"}, first_act, first_exp);
    check((useb ? rok_b : rok_a) == all_good, {req, " read_ok"}, 32'(useb ? rok_b : rok_a), 32'(all_good));
  endtask

  task automatic run_prog(input string req, input int a, input logic [31:0] d, input int cnt, input bit also_rd);
    bit good;
    good = (cnt == 1) && (a < NW) && !lock[a / SW];
    wait_idle();
    addr = AW'(a); wdata = d; bcnt = BCW'(cnt); wr = 1'b1; rd = also_rd; wrap = 1'b0;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
    if (also_rd) begin
      check(busy_a == 2'b11, {req, " R11 read wins"}, 32'(busy_a), 32'h3);
    end else begin
      check(busy_a == 2'b10 && wait_a, {req, " R9 busy programming"}, 32'(busy_a), 32'h2);
      @(negedge clk);
      check(wok_a == good, {req, " write_ok"}, 32'(wok_a), 32'(good));
      if (good) model[a] = model[a] & d;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) model[i] = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!wait_a && !rv_a && busy_a == 2'b00 && !rok_a && !wok_a, "R1 reset outputs",
          {wait_a, rv_a, busy_a, rok_a, wok_a}, 32'h0);
    rst_n = 1'b1;
    run_read("R1 erased word", 5, 1, 0, 0);

    // fill array (R7)
    for (int i = 0; i < NW; i++)
      run_prog("R7 fill", i, {8'hC3, 8'(i), ~8'(i), 8'h5A}, 1, 0);
    run_prog("R7 and with old", 10, 32'h0000_FFFF, 1, 0);
    run_read("R7 readback", 10, 1, 0, 0);

    // R8 failures
    run_prog("R8 count 2", 11, 32'h0, 2, 0);
    run_prog("R8 count 0", 12, 32'h0, 0, 0);
    run_prog("R8 out of range", 200, 32'h0, 1, 0);
    lock = 3'b010;
    run_prog("R8 locked sector", 70, 32'h0, 1, 0);
    run_read("R6 locked read", 70, 1, 0, 0);
    run_read("R6 burst into locked", 62, 4, 0, 0);
    lock = 3'b000;
    run_read("R8 readback", 11, 2, 0, 0);
    run_read("R8 readback locked word", 70, 1, 0, 0);

    // R2 incrementing
    run_read("R2 single", 3, 1, 0, 0);
    run_read("R2 nine", 17, 9, 0, 0);
    run_read("R2 max 128", 50, 128, 0, 0);
    // R3 rollover
    run_read("R3 past end", 188, 8, 0, 0);
    // R4 wrapping
    run_read("R4 wrap4 from 2", 2, 4, 1, 0);
    run_read("R4 wrap4 from 7", 7, 4, 1, 0);
    run_read("R4 wrap4 top block", 190, 4, 1, 0);
    run_read("R4 wrap2 from 1", 1, 2, 1, 1);
    // R5 illegal counts
    run_read("R5 wrap count 3", 5, 3, 1, 0);
    run_read("R5 incr count 0", 5, 0, 0, 0);
    run_read("R5 incr count 200", 5, 200, 0, 0);
    // R6 illegal start
    run_read("R6 start out of range", 195, 2, 0, 0);
    // R11 simultaneous read and write
    run_prog("R11 both", 20, 32'h0, 1, 1);
    wait_idle();
    run_read("R11 write dropped", 20, 1, 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule